// File: doc/BRIEF.md
# Address-Masked Eight-Line GPIO Port

This block is an eight-line general purpose I/O port behind a simple memory-mapped bus with a valid, a write strobe, a byte address and 8-bit write and read data. It holds a direction register and an output data register. It drives a per-line output enable and a per-line output value toward the pad ring, and it samples the pad inputs through a two-flop synchronizer.

The data register is reached through a 1 KiB window. Inside that window, address bits [9:2] act as a per-line mask. A write changes only the selected output bits. A read returns only the selected lines and gives zero in every other position. Software can therefore set or clear a single pin in one bus access, without a read-modify-write sequence that could race another agent.

The synchronized input samples are also exported on their own port, so that a separate interrupt block can use them. Reads return data one cycle after the request, and the bus never stalls.

Top module: `gpio_mask_port`

## Requirements
- R1: The port has 8 lines. A data access is an aligned access at a byte address below 0x400. Address bit (n+2) selects line n, so a mask with a single bit set reaches exactly one line.
- R2: A data write sets each output bit whose mask bit is 1 to the matching `bus_wdata` bit. Every other output bit keeps its value. The new value is on `pin_out` in the cycle after the write.
- R3: A data read returns 0 in every bit position whose mask bit is 0.
- R4: For an input line (direction bit 0), a data read returns the pin level after a two-flop synchronizer. A change on `pin_in` reaches the read path and `pin_sync` on the second rising edge after it.
- R5: For an output line (direction bit 1), a data read returns the value driven on `pin_out`, whatever the pin input is.
- R6: The direction register sits at byte address 0x400. Bit n set to 1 makes line n an output, and `pin_oe[n]` follows the register in the cycle after the write. Reading 0x400 returns the register. Only a write to 0x400 changes `pin_oe`.
- R7: The data register is written even while a line is an input. When the line is later switched to output, it drives the stored value.
- R8: While `rst_n` is low at a rising edge, the direction register, the data register, the synchronizer and `bus_rdata` are cleared to 0.
- R9: An access is unmapped if its address has bits [1:0] nonzero or is at or above 0x404. A read of an unmapped address returns 0. A write to an unmapped address changes neither `pin_out` nor `pin_oe`.
- R10: Read data appears on `bus_rdata` in the cycle after the read request. `bus_rdata` is 0 in any cycle that does not follow a read.
- R11: `pin_sync` carries the synchronized input levels of all lines, whatever their direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after the request |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| pin_oe | output | 8 | Per-line output enable |
| pin_out | output | 8 | Per-line output value |
| pin_sync | output | 8 | Synchronized input samples for the interrupt block |

## Verification
The assertions assume that the bus inputs are stable and free of X around each rising edge while `bus_valid` is high. They also assume that every access lasts exactly one cycle, so that a request in cycle N owns the read data in cycle N+1. The bench drives all bus and pin inputs on the falling edge and holds `bus_valid` for a single cycle per access, which keeps to those assumptions. It sweeps all 256 masks under several direction patterns, and it changes `pin_in` only in idle stretches longer than the synchronizer depth.

// File: rtl/gpio_port_pkg.sv
// Package: shared types for the address-masked GPIO port.
// Assumes: nothing; holds only the access-select encoding.
package gpio_port_pkg;

    // Which register a bus access reaches
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_DIR  = 2'd2
    } gpio_sel_e;

endpackage

// File: rtl/gpio_in_sync.sv
// Module: multi-stage synchronizer for the asynchronous pad inputs.
// Assumes: each bit is an independent level; STAGES >= 2.
module gpio_in_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // first capture flop
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= async_in;
                end
            end else begin : g_next
                // further resolution flops
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_addr_decode.sv
// Module: decodes a bus address into a register select and a line mask.
// Assumes: the data window spans 4*2^LINES bytes from 0; DIR_OFFSET lies above it.
module gpio_addr_decode
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int LINES      = 8,
    parameter int DIR_OFFSET = 'h400
) (
    input  logic [ADDR_W-1:0] addr,
    output gpio_sel_e         sel,
    output logic [LINES-1:0]  mask
);
    localparam int SPAN_BITS = LINES + 2;
    localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(DIR_OFFSET);

    logic aligned;
    logic in_data;
    logic is_dir;

    // classify the access
    always_comb begin
        aligned = (addr[1:0] == 2'b00);
        in_data = (addr[ADDR_W-1:SPAN_BITS] == '0);
        is_dir  = (addr[ADDR_W-1:2] == DIR_ADDR[ADDR_W-1:2]);
        if (!aligned)     sel = SEL_NONE;
        else if (in_data) sel = SEL_DATA;
        else if (is_dir)  sel = SEL_DIR;
        else              sel = SEL_NONE;
    end

    assign mask = addr[SPAN_BITS-1:2];
endmodule

// File: rtl/gpio_ctrl_regs.sv
// Module: direction and output-data registers with per-line masked data writes.
// Assumes: sel and mask come from gpio_addr_decode in the same cycle.
module gpio_ctrl_regs
    import gpio_port_pkg::*;
#(
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  gpio_sel_e        sel,
    input  logic [LINES-1:0] mask,
    input  logic [LINES-1:0] wdata,
    output logic [LINES-1:0] dir_q,
    output logic [LINES-1:0] out_q
);
    // direction register, whole-byte write
    always_ff @(posedge clk) begin
        if (!rst_n)                         dir_q <= '0;
        else if (wr_en && sel == SEL_DIR)   dir_q <= wdata;
    end

    // output data register, masked write per line
    always_ff @(posedge clk) begin
        if (!rst_n)                         out_q <= '0;
        else if (wr_en && sel == SEL_DATA)  out_q <= (out_q & ~mask) | (wdata & mask);
    end
endmodule

// File: rtl/gpio_read_path.sv
// Module: registered read mux; one cycle of latency, zero when no read.
// Assumes: a read request lasts one cycle.
module gpio_read_path
    import gpio_port_pkg::*;
#(
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  gpio_sel_e        sel,
    input  logic [LINES-1:0] mask,
    input  logic [LINES-1:0] dir_q,
    input  logic [LINES-1:0] out_q,
    input  logic [LINES-1:0] sync_in,
    output logic [LINES-1:0] rdata
);
    logic [LINES-1:0] line_view;
    logic [LINES-1:0] rdata_d;

    // pick driven value for outputs, sampled level for inputs
    always_comb begin
        line_view = (dir_q & out_q) | (~dir_q & sync_in);
        rdata_d   = '0;
        if (rd_en) begin
            case (sel)
                SEL_DATA: rdata_d = line_view & mask;
                SEL_DIR:  rdata_d = dir_q;
                default:  rdata_d = '0;
            endcase
        end
    end

    // register the read result
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rdata_d;
    end
endmodule

// File: rtl/gpio_mask_port.sv
// Module: top of the address-masked eight-line GPIO port.
// Assumes: single-cycle bus accesses, no wait states; pads modelled as oe/out.
module gpio_mask_port
    import gpio_port_pkg::*;
#(
    parameter int LINES       = 8,
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2,
    parameter int DIR_OFFSET  = 'h400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [LINES-1:0]  bus_wdata,
    output logic [LINES-1:0]  bus_rdata,
    input  logic [LINES-1:0]  pin_in,
    output logic [LINES-1:0]  pin_oe,
    output logic [LINES-1:0]  pin_out,
    output logic [LINES-1:0]  pin_sync
);
    gpio_sel_e        acc_sel;
    logic [LINES-1:0] acc_mask;
    logic [LINES-1:0] dir_q;
    logic [LINES-1:0] out_q;
    logic             wr_en;
    logic             rd_en;

    assign wr_en = bus_valid &  bus_write;
    assign rd_en = bus_valid & ~bus_write;

    gpio_addr_decode #(
        .ADDR_W(ADDR_W), .LINES(LINES), .DIR_OFFSET(DIR_OFFSET)
    ) u_decode (
        .addr(bus_addr), .sel(acc_sel), .mask(acc_mask)
    );

    gpio_ctrl_regs #(.LINES(LINES)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(acc_sel),
        .mask(acc_mask), .wdata(bus_wdata), .dir_q(dir_q), .out_q(out_q)
    );

    gpio_in_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pin_sync)
    );

    gpio_read_path #(.LINES(LINES)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .sel(acc_sel), .mask(acc_mask),
        .dir_q(dir_q), .out_q(out_q), .sync_in(pin_sync), .rdata(bus_rdata)
    );

    assign pin_oe  = dir_q;
    assign pin_out = out_q;
endmodule

// File: rtl/gpio_mask_port_chk.sv
// Module: assertion checker for gpio_mask_port, bound to every instance.
// Assumes: bus inputs are known and one-cycle per access while bus_valid is high.
module gpio_mask_port_chk #(
    parameter int LINES      = 8,
    parameter int ADDR_W     = 12,
    parameter int DIR_OFFSET = 'h400
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [LINES-1:0]  bus_wdata,
    input logic [LINES-1:0]  bus_rdata,
    input logic [LINES-1:0]  pin_oe,
    input logic [LINES-1:0]  pin_out
);
    localparam logic [ADDR_W-1:0] DIR_A = ADDR_W'(DIR_OFFSET);

    logic             c_align;
    logic             c_data;
    logic             c_dir;
    logic [LINES-1:0] c_mask;

    // port-level view of the access class
    always_comb begin
        c_align = (bus_addr[1:0] == 2'b00);
        c_data  = c_align && (bus_addr[ADDR_W-1:LINES+2] == '0);
        c_dir   = c_align && (bus_addr == DIR_A);
        c_mask  = bus_addr[LINES+1:2];
    end

    assert_unmasked_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && c_data) |=>
        (((pin_out ^ $past(pin_out)) & ~$past(c_mask)) == '0));

    assert_masked_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && c_data) |=>
        ((pin_out & $past(c_mask)) == ($past(bus_wdata) & $past(c_mask))));

    assert_read_unmasked_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && c_data) |=> ((bus_rdata & ~$past(c_mask)) == '0));

    assert_oe_only_by_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && bus_write && c_dir) |=> $stable(pin_oe));

    assert_unmapped_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && !c_data && !c_dir) |=> (bus_rdata == '0));

    assert_unmapped_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && !c_data && !c_dir) |=> ($stable(pin_out) && $stable(pin_oe)));

    assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> (bus_rdata == '0));
endmodule

bind gpio_mask_port gpio_mask_port_chk #(
    .LINES(LINES), .ADDR_W(ADDR_W), .DIR_OFFSET(DIR_OFFSET)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_oe(pin_oe), .pin_out(pin_out)
);

// File: tb/gpio_mask_port_tb.sv
`timescale 1ns/1ps
module gpio_mask_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_oe;
    logic [7:0]  pin_out;
    logic [7:0]  pin_sync;

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] m_out = '0;
    logic [7:0] m_dir = '0;

    always #4 clk = ~clk;

    gpio_mask_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .pin_sync(pin_sync)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // write at negedge; result visible at the following negedge
    task automatic bwr(input logic [11:0] a, input logic [7:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    // read at negedge; data sampled one cycle later
    task automatic brd(input logic [11:0] a, output logic [7:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [7:0] exp_read(input logic [7:0] msk);
        return ((m_dir & m_out) | (~m_dir & pin_in)) & msk;
    endfunction

    initial begin
        logic [7:0] rd;
        @(negedge clk);
        idle(3);
        // R8: reset state
        check("R8 oe", pin_oe, 8'h00);
        check("R8 out", pin_out, 8'h00);
        check("R8 rdata", bus_rdata, 8'h00);
        check("R8 sync", pin_sync, 8'h00);
        rst_n = 1'b1;
        idle(1);
        brd(12'h400, rd); check("R8 dir read", rd, 8'h00);
        brd(12'h3FC, rd); check("R8 data read", rd, 8'h00);

        // R4 / R11: two-edge synchronizer delay
        pin_in = 8'hC3;
        idle(1);
        check("R4 sync after 1 edge", pin_sync, 8'h00);
        idle(1);
        check("R11 sync after 2 edges", pin_sync, 8'hC3);
        brd(12'h3FC, rd); check("R4 input read", rd, 8'hC3);
        idle(1);
        check("R10 idle rdata", bus_rdata, 8'h00);

        // R7: data held while input, driven after switching to output
        bwr(12'h3FC, 8'hFF); m_out = 8'hFF;
        check("R7 out stored", pin_out, 8'hFF);
        check("R7 oe still off", pin_oe, 8'h00);
        bwr(12'h400, 8'h0F); m_dir = 8'h0F;
        check("R6 oe", pin_oe, 8'h0F);
        check("R7 out driven", pin_out & pin_oe, 8'h0F);
        brd(12'h3FC, rd); check("R5 mixed read", rd, 8'hCF);

        // R1: single-line masks reach exactly one line
        bwr(12'h3FC, 8'h00); m_out = 8'h00;
        for (int n = 0; n < 8; n++) begin
            bwr(12'(1 << (n + 2)), 8'hFF);
            m_out[n] = 1'b1;
            check("R1 single line", pin_out, m_out);
        end

        // R2/R3/R5/R6: full mask sweep under several direction patterns
        for (int p = 0; p < 4; p++) begin
            logic [7:0] dpat;
            dpat = (p == 0) ? 8'h00 : (p == 1) ? 8'hFF : (p == 2) ? 8'hA5 : 8'h3C;
            pin_in = ~dpat ^ 8'h96;
            bwr(12'h400, dpat); m_dir = dpat;
            idle(3);
            brd(12'h400, rd); check("R6 dir read", rd, dpat);
            for (int m = 0; m < 256; m++) begin
                logic [7:0] wd;
                wd = 8'(m * 37 + p * 11);
                bwr(12'(m << 2), wd);
                m_out = (m_out & ~8'(m)) | (wd & 8'(m));
                check("R2 masked write", pin_out, m_out);
                check("R6 oe stable", pin_oe, dpat);
                brd(12'(m << 2), rd);
                check("R3 R5 masked read", rd, exp_read(8'(m)));
            end
        end

        // R9: unmapped and unaligned addresses
        for (int k = 0; k < 5; k++) begin
            logic [11:0] ua;
            logic [7:0]  so, sd;
            ua = (k == 0) ? 12'h404 : (k == 1) ? 12'h800 : (k == 2) ? 12'hFFC :
                 (k == 3) ? 12'h401 : 12'h3FE;
            so = pin_out; sd = pin_oe;
            bwr(ua, ~so);
            check("R9 write ignored out", pin_out, so);
            check("R9 write ignored oe", pin_oe, sd);
            brd(ua, rd); check("R9 read zero", rd, 8'h00);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule